// File: doc/BRIEF.md
# Sum of Absolute Differences Unit

This block serves motion estimation. Each call takes eight unsigned 8-bit pixels from a reference block and eight from a candidate block. For each of the eight pixel pairs it forms the absolute difference. It then adds the eight differences together and folds the total into a running accumulator. The subtractions, magnitudes and additions are all done in the same clock cycle.

A search engine outside this block feeds one row slice of a block per call. It issues a clear at the start of each candidate and reads the accumulated distortion at the end. The engine also handles addressing, the search pattern and choosing the best match.

The accumulator sits in a register and only changes on cycles that carry a valid call or a clear.

Top module: `sad_unit`

## Requirements
- R1: A synchronous active-high reset drives the accumulator output to zero at the clock edge where it is sampled, and this overrides every other input.
- R2: Pixel lane i occupies bits [8i+7:8i] of both pixel vectors, and lane i contributes |ref_i - cand_i| to the total. The pixels are unsigned, so the result does not depend on which vector holds the larger value.
- R3: On a clock edge with the valid input high and the clear input low, the accumulator gains the sum of the eight lane differences. The new value shows at the output right after that edge.
- R4: On a clock edge with the valid input low, the pixel inputs have no effect and the accumulator holds its value.
- R5: On a clock edge with the clear input high and the valid input low, the accumulator becomes zero.
- R6: On a clock edge with both the clear and valid inputs high, the accumulator loads only the current call's sum. The previous total is dropped.
- R7: The accumulator is 16 bits wide and wraps modulo 65536. This width holds a full 16x16 block (32 calls of at most 2040 each) without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_px | input | 64 | Eight packed reference pixels, lane 0 in the low byte |
| cand_px | input | 64 | Eight packed candidate pixels, lane 0 in the low byte |
| px_vld | input | 1 | The pixel vectors carry a call this cycle |
| acc_clr | input | 1 | Restart the running total |
| sad_acc | output | 16 | Registered running sum of absolute differences |

## Verification
The clocked assertions expect the clear and valid controls to be driven to known levels from the first clock after reset. The bench sets both low before it releases reset and changes them only half a cycle away from the active edge. The lane and tree checks expect pixel vectors that carry no unknown bits whenever valid is high. Every table row and directed call therefore drives fully defined vectors. The stimulus includes calls that reach the largest per-call sum of 2040, so the tree's range check is exercised at its limit.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned SAD_LANES_DEF = 8;
  localparam int unsigned SAD_PIX_W_DEF = 8;
  localparam int unsigned SAD_ACC_W_DEF = 16;

  function automatic int unsigned sad_sum_width(int unsigned pix_w, int unsigned lanes);
    return pix_w + $clog2(lanes);
  endfunction
endpackage

// File: rtl/sad_lane.sv
module sad_lane #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] pa,
  input  logic [PIX_W-1:0] pb,
  output logic [PIX_W-1:0] mag
);
  logic [PIX_W:0] dif;
  logic [PIX_W:0] dif_neg;

  always_comb begin
    dif     = {1'b0, pa} - {1'b0, pb};
    dif_neg = -dif;
    mag     = dif[PIX_W] ? dif_neg[PIX_W-1:0] : dif[PIX_W-1:0];
  end

  // the magnitude added back to the smaller pixel must give the larger one
  always_comb begin
    if (pa >= pb) begin
      AST_LANE_UP: assert ({1'b0, pb} + {1'b0, mag} == {1'b0, pa}); // R2
    end else if (pa < pb) begin
      AST_LANE_DN: assert ({1'b0, pa} + {1'b0, mag} == {1'b0, pb}); // R2
    end
  end
endmodule

// File: rtl/sad_tree.sv
module sad_tree #(
  parameter int unsigned LANES = 8,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned SUM_W = 11
) (
  input  logic [LANES*PIX_W-1:0] mags,
  output logic [SUM_W-1:0]       total
);
  localparam int unsigned MAX_TOTAL = LANES * ((1 << PIX_W) - 1);

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) begin
      total = total + SUM_W'(mags[i*PIX_W +: PIX_W]);
    end
  end

  always_comb begin
    if (!$isunknown(mags)) begin
      AST_SUM_RANGE: assert (32'(total) <= MAX_TOTAL); // R3
    end
  end
endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
  parameter int unsigned SUM_W = 11,
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             clr,
  input  logic [SUM_W-1:0] inc,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] inc_ext;
  assign inc_ext = ACC_W'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (clr) begin
      acc <= vld ? inc_ext : '0;
    end else if (vld) begin
      acc <= acc + inc_ext;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!vld && !clr) |=> $stable(acc)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clr && !vld) |=> (acc == '0)); // R5
  AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (clr && vld) |=> (acc == ACC_W'($past(inc)))); // R6
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (acc == '0)); // R1
endmodule

// File: rtl/sad_unit.sv
module sad_unit
  import sad_pkg::*;
#(
  parameter int unsigned LANES = SAD_LANES_DEF,
  parameter int unsigned PIX_W = SAD_PIX_W_DEF,
  parameter int unsigned ACC_W = SAD_ACC_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*PIX_W-1:0] ref_px,
  input  logic [LANES*PIX_W-1:0] cand_px,
  input  logic                   px_vld,
  input  logic                   acc_clr,
  output logic [ACC_W-1:0]       sad_acc
);
  localparam int unsigned SUM_W = sad_sum_width(PIX_W, LANES);

  logic [LANES*PIX_W-1:0] lane_mag;
  logic [SUM_W-1:0]       call_sum;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sad_lane #(.PIX_W(PIX_W)) u_lane (
      .pa  (ref_px[g*PIX_W +: PIX_W]),
      .pb  (cand_px[g*PIX_W +: PIX_W]),
      .mag (lane_mag[g*PIX_W +: PIX_W])
    );
  end

  sad_tree #(.LANES(LANES), .PIX_W(PIX_W), .SUM_W(SUM_W)) u_tree (
    .mags  (lane_mag),
    .total (call_sum)
  );

  sad_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
    .clk (clk),
    .rst (rst),
    .vld (px_vld),
    .clr (acc_clr),
    .inc (call_sum),
    .acc (sad_acc)
  );
endmodule

// File: tb/sim_sad_unit.sv
module sim_sad_unit;
  localparam int CLK_PER = 10;
  localparam int NROW = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] ref_px, cand_px;
  logic        px_vld, acc_clr;
  logic [15:0] sad_acc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  sad_unit u0 (
    .clk(clk), .rst(rst), .ref_px(ref_px), .cand_px(cand_px),
    .px_vld(px_vld), .acc_clr(acc_clr), .sad_acc(sad_acc)
  );

  // table: reference, candidate, clear, valid, expected total after the edge
  localparam logic [63:0] T_REF [NROW] = '{
    64'h0000000000000000,  // R6 clear+valid, 8*255
    64'h0102030405060708,  // R3 R2 mixed signs, 32
    64'h0807060504030201,  // R2 swapped, 32
    64'hFFFFFFFFFFFFFFFF,  // R4 ignored
    64'h1010101010101010,  // R3 equal pixels
    64'h8000000000000000,  // R2 top lane only, 128
    64'h0000000000000000,  // R5 clear alone
    64'h00000000000000FF   // R2 bottom lane only, 254
  };
  localparam logic [63:0] T_CAN [NROW] = '{
    64'hFFFFFFFFFFFFFFFF, 64'h0807060504030201, 64'h0102030405060708,
    64'h0000000000000000, 64'h1010101010101010, 64'h0000000000000000,
    64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001
  };
  localparam logic T_CLR [NROW] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic T_VLD [NROW] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [15:0] T_EXP [NROW] = '{
    16'd2040, 16'd2072, 16'd2104, 16'd2104, 16'd2104, 16'd2232, 16'd0, 16'd254
  };
  localparam string T_TAG [NROW] = '{"R6", "R3", "R2", "R4", "R3", "R2", "R5", "R2"};

  task automatic check(input string tag, input logic [15:0] exp_v);
    checks++;
    if (sad_acc !== exp_v) begin
      errors++;
      $display("FAIL %s: sad_acc=%0d expected=%0d", tag, sad_acc, exp_v);
    end
  endtask

  task automatic call(input logic [63:0] r, input logic [63:0] c,
                      input logic cl, input logic v);
    @(negedge clk);
    ref_px = r; cand_px = c; acc_clr = cl; px_vld = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; px_vld = 1'b0; acc_clr = 1'b0;
    ref_px = '0; cand_px = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 16'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      call(T_REF[i], T_CAN[i], T_CLR[i], T_VLD[i]);
      check(T_TAG[i], T_EXP[i]);
    end

    // R7: 32 full-scale calls fit, the 33rd wraps
    call(64'h0, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b1);
    for (int i = 1; i < 32; i++) call(64'hFFFFFFFFFFFFFFFF, 64'h0, 1'b0, 1'b1);
    check("R7 no wrap at 32 calls", 16'd65280);
    call(64'hFFFFFFFFFFFFFFFF, 64'h0, 1'b0, 1'b1);
    check("R7 wrap", 16'd1784);

    // R4: valid low with extreme pixels and no clear keeps the total
    call(64'h0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0);
    check("R4 hold", 16'd1784);

    // R1: reset overrides a concurrent valid call
    @(negedge clk);
    rst = 1'b1; px_vld = 1'b1; ref_px = 64'hFF; cand_px = 64'h0;
    @(posedge clk); #1;
    check("R1 reset over valid", 16'd0);
    @(negedge clk);
    rst = 1'b0; px_vld = 1'b0;

    // R2: lane 3 alone, candidate larger
    call(64'h0000000000000000, 64'h00000000C8000000, 1'b0, 1'b1);
    check("R2 lane3", 16'd200);
    // R6: clear with valid drops the earlier 200
    call(64'h0000000000000005, 64'h0000000000000002, 1'b1, 1'b1);
    check("R6 load only", 16'd3);

    @(negedge clk);
    px_vld = 1'b0; acc_clr = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule